// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flag-Tagged Receive Queue

This block recovers asynchronous serial characters from a single receive line sampled at sixteen times the bit rate. The sampling rate is derived from the system clock by a programmable divisor. Each finished character goes into a receive queue together with its own status bits: break, overrun, parity error and framing error. Reading the queue returns one 12-bit word that carries the character and its status. The status bits travel with the character they describe, so software never has to line up a separate status register with the data stream.

The frame can be set to 5 to 8 data bits, with or without parity (even or odd) and with one or two stop bits. With queueing enabled the receiver buffers up to 16 characters. With queueing disabled it holds a single character. Three outputs support flow handling. A receive-empty flag shows whether anything is waiting. A level-triggered receive request uses a fill threshold. A one-cycle timeout pulse reports characters that have been sitting unread while the line is quiet. Configuration inputs are expected to change only while the line is idle and, for the queue mode, only while the queue is empty.

Top module: `serial_rx_fifo`

## Requirements
- R1: The read word `rd_data` carries the character in bits 7:0, framing error in bit 8, parity error in bit 9, overrun in bit 10 and break in bit 11, and shows the oldest stored entry while `rx_empty` is low.
- R2: `word_len` selects the number of data bits (00 = 5, 01 = 6, 10 = 7, 11 = 8). Bits arrive least significant first, and character bits above the selected length read as zero.
- R3: With `parity_en` high, one parity bit follows the data. `parity_even` high requires an even count of ones over data plus parity, and low requires an odd count. A mismatch sets bit 9. With `parity_en` low, no parity bit is expected and bit 9 stays clear.
- R4: One stop bit is expected, or two when `two_stop` is high. If any stop bit is sampled low, bit 8 is set (unless the frame is a break).
- R5: A frame whose data, parity and stop bits are all low is stored as a break: bit 11 set, character zero, bits 8 and 9 clear. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: Characters are read in arrival order. The queue holds 16 entries when `fifo_en` is high and exactly one when it is low.
- R7: A character that completes while the queue is full is discarded, and bit 10 is set on the most recently stored entry.
- R8: `rx_empty` is high exactly when no character is waiting, including after reset.
- R9: `rx_irq` is high when at least 8 entries are stored with `fifo_en` high, or when any entry is stored with `fifo_en` low.
- R10: `rx_timeout` pulses for one cycle once 32 bit-times pass with the queue non-empty and the receiver idle. A new start bit or emptying the queue rearms it.
- R11: A start bit is accepted only if the line is still low at its midpoint (8 sample ticks in). A shorter low glitch produces no character.
- R12: A read request while `rx_empty` is high changes nothing: no entry appears and the next real character is read intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 16 | Sample tick every divisor+1 clocks (16 ticks per bit) |
| word_len | input | 2 | Data bit count code |
| parity_en | input | 1 | Expect a parity bit |
| parity_even | input | 1 | Even parity when high, odd when low |
| two_stop | input | 1 | Expect two stop bits |
| fifo_en | input | 1 | 16-entry queue when high, single holding entry when low |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 12 | Oldest entry: flags and character |
| rx_empty | output | 1 | No character waiting |
| rx_irq | output | 1 | Receive service request |
| rx_timeout | output | 1 | One-cycle receive timeout pulse |

## Verification
The assertions assume several things about the inputs. The frame configuration and `divisor` change only while the receiver is idle. `fifo_en` changes only when the queue is empty. `rx_in` holds each bit level for a whole bit-time of 16 sample ticks. The stimulus meets these assumptions. It drives the line bit by bit, each bit exactly 16 ticks wide. It leaves a high gap after every frame so the receiver returns to idle, and it drains the queue before changing the queue mode. It alters the frame settings only between frames. Random frames mix lengths, parity modes, stop counts, corrupted parity, low stop bits and all-zero breaks.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_PAR,
    RS_STOP,
    RS_WAITH
  } rx_state_t;

  typedef struct packed {
    logic       brk;
    logic       ovr;
    logic       pe;
    logic       fe;
    logic [7:0] ch;
  } rx_word_t;

  localparam int OVS = 16;

endpackage

// File: rtl/rxq_tick.sv
module rxq_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= divisor;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/rxq_deframer.sv
module rxq_deframer
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic       two_stop,
  output logic       push,
  output logic [7:0] ch,
  output logic       fe,
  output logic       pe,
  output logic       brk,
  output logic       busy
);

  rx_state_t  st;
  logic [3:0] ph;
  logic [2:0] bi;
  logic [7:0] sh;
  logic       pbit;
  logic       stop0;
  logic       sidx;
  logic [3:0] nbits;

  assign nbits = {2'b00, word_len} + 4'd5;
  assign busy  = (st != RS_IDLE);

  // frame evaluation at the final stop sample
  logic all_low, any_low, is_brk, par_x;
  always_comb begin
    all_low = !rx && (!two_stop || !stop0);
    any_low = !rx || (two_stop && !stop0);
    is_brk  = all_low && (sh == 8'h00) && (!parity_en || !pbit);
    par_x   = (^sh) ^ pbit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RS_IDLE;
      ph    <= '0;
      bi    <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      stop0 <= 1'b1;
      sidx  <= 1'b0;
      push  <= 1'b0;
      ch    <= '0;
      fe    <= 1'b0;
      pe    <= 1'b0;
      brk   <= 1'b0;
    end else begin
      push <= 1'b0;
      unique case (st)
        RS_IDLE: begin
          if (tick && !rx) begin
            st <= RS_START;
            ph <= '0;
          end
        end
        RS_START: begin
          if (tick) begin
            if (ph == 4'd7) begin
              if (!rx) begin
                st    <= RS_DATA;
                ph    <= '0;
                bi    <= '0;
                sh    <= '0;
                pbit  <= 1'b0;
                stop0 <= 1'b1;
              end else begin
                st <= RS_IDLE;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        RS_DATA: begin
          if (tick) begin
            ph <= ph + 1'b1;
            if (ph == 4'd15) begin
              sh[bi] <= rx;
              if ({1'b0, bi} == nbits - 4'd1) begin
                st   <= parity_en ? RS_PAR : RS_STOP;
                sidx <= 1'b0;
              end else begin
                bi <= bi + 1'b1;
              end
            end
          end
        end
        RS_PAR: begin
          if (tick) begin
            ph <= ph + 1'b1;
            if (ph == 4'd15) begin
              pbit <= rx;
              st   <= RS_STOP;
              sidx <= 1'b0;
            end
          end
        end
        RS_STOP: begin
          if (tick) begin
            ph <= ph + 1'b1;
            if (ph == 4'd15) begin
              if (two_stop && !sidx) begin
                stop0 <= rx;
                sidx  <= 1'b1;
              end else begin
                push <= 1'b1;
                ch   <= sh;
                brk  <= is_brk;
                fe   <= any_low && !is_brk;
                pe   <= parity_en && !is_brk && (parity_even ? par_x : !par_x);
                st   <= any_low ? RS_WAITH : RS_IDLE;
              end
            end
          end
        end
        RS_WAITH: begin
          if (rx) st <= RS_IDLE;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  // R5: a break entry carries a zero character and no parity/framing flag
  a_r5_break_clean: assert property (@(posedge clk) disable iff (rst)
    (push && brk) |-> (ch == 8'h00 && !fe && !pe));

  // R2: no character bit above the configured length is ever set
  a_r2_len_mask: assert property (@(posedge clk) disable iff (rst)
    push |-> ((ch >> nbits) == 8'h00));

  // R11: the data phase is only entered from a start bit still low
  a_r11_start_mid: assert property (@(posedge clk) disable iff (rst)
    (st == RS_START && tick && ph == 4'd7 && rx) |=> (st == RS_IDLE));

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fifo_en,
  input  logic        push,
  input  logic [7:0]  ch,
  input  logic        fe,
  input  logic        pe,
  input  logic        brk,
  input  logic        pop,
  output logic [11:0] rd_data,
  output logic        empty,
  output logic        irq
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [10:0]   mem [DEPTH];
  logic [DEPTH-1:0] ovr_q;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, cnt_nx;
  logic full, do_pop, do_push, ovr_set;

  always_comb begin
    full    = fifo_en ? (count == CW'(DEPTH)) : (count != '0);
    do_pop  = pop && (count != '0);
    do_push = push && (!full || do_pop);
    ovr_set = push && full && !do_pop;
    cnt_nx  = count + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= {brk, pe, fe, ch};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr_q  <= '0;
      empty  <= 1'b1;
      irq    <= 1'b0;
    end else begin
      if (do_push) begin
        wr_ptr         <= wr_ptr + 1'b1;
        ovr_q[wr_ptr]  <= 1'b0;
      end
      if (ovr_set) ovr_q[wr_ptr - AW'(1)] <= 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      count <= cnt_nx;
      empty <= (cnt_nx == '0);
      irq   <= fifo_en ? (cnt_nx >= CW'(THRESH)) : (cnt_nx != '0);
    end
  end

  rx_word_t head;
  logic [10:0] head_raw;
  assign head_raw = mem[rd_ptr];
  always_comb begin
    head.brk = head_raw[10];
    head.ovr = ovr_q[rd_ptr];
    head.pe  = head_raw[9];
    head.fe  = head_raw[8];
    head.ch  = head_raw[7:0];
  end
  assign rd_data = head;

  // R6: occupancy never exceeds the physical depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R7: a character arriving at a full queue leaves occupancy unchanged
  a_r7_full_hold: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(count));

  // R12: popping an empty queue without a push keeps it empty
  a_r12_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout
  import rxq_pkg::*;
#(
  parameter int TO_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic busy,
  input  logic empty,
  output logic pulse
);

  localparam int LIMIT = TO_BITS * OVS;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          fired;

  always_ff @(posedge clk) begin
    if (rst || busy || empty) begin
      cnt   <= '0;
      fired <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick && !fired) begin
        if (cnt == CW'(LIMIT - 1)) begin
          pulse <= 1'b1;
          fired <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R10: the timeout indication lasts a single cycle
  a_r10_single: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R10: it only follows a cycle where data was waiting
  a_r10_nonempty: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(!empty));

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int DEPTH   = 16,
  parameter int THRESH  = 8,
  parameter int DIV_W   = 16,
  parameter int TO_BITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       word_len,
  input  logic             parity_en,
  input  logic             parity_even,
  input  logic             two_stop,
  input  logic             fifo_en,
  input  logic             rx_in,
  input  logic             rd_en,
  output logic [11:0]      rd_data,
  output logic             rx_empty,
  output logic             rx_irq,
  output logic             rx_timeout
);

  logic [1:0] sync_q;
  logic       tick, push, fe, pe, brk, busy;
  logic [7:0] ch;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rx_in};
  end

  rxq_tick #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
  );

  rxq_deframer i_deframer (
    .clk(clk), .rst(rst), .tick(tick), .rx(sync_q[1]),
    .word_len(word_len), .parity_en(parity_en), .parity_even(parity_even),
    .two_stop(two_stop), .push(push), .ch(ch), .fe(fe), .pe(pe),
    .brk(brk), .busy(busy)
  );

  rxq_fifo #(.DEPTH(DEPTH), .THRESH(THRESH)) i_fifo (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .push(push), .ch(ch),
    .fe(fe), .pe(pe), .brk(brk), .pop(rd_en), .rd_data(rd_data),
    .empty(rx_empty), .irq(rx_irq)
  );

  rxq_timeout #(.TO_BITS(TO_BITS)) i_timeout (
    .clk(clk), .rst(rst), .tick(tick), .busy(busy), .empty(rx_empty),
    .pulse(rx_timeout)
  );

  // R9: in single-entry mode the request follows occupancy exactly
  a_r9_single_irq: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && $stable(fifo_en)) |-> (rx_irq == !rx_empty));

endmodule

// File: tb/test_serial_rx_fifo.sv
module test_serial_rx_fifo;

  localparam int DIV = 1;
  localparam int BIT = 16 * (DIV + 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] divisor = 16'(DIV);
  logic [1:0]  word_len = 2'b11;
  logic        parity_en = 1'b0, parity_even = 1'b0, two_stop = 1'b0;
  logic        fifo_en = 1'b1, rx_in = 1'b1, rd_en = 1'b0;
  logic [11:0] rd_data;
  logic        rx_empty, rx_irq, rx_timeout;

  int n_chk = 0, n_bad = 0, to_cnt = 0;
  logic [11:0] q[$];

  always #5 clk = ~clk;

  serial_rx_fifo i_serial_rx_fifo (
    .clk(clk), .rst(rst), .divisor(divisor), .word_len(word_len),
    .parity_en(parity_en), .parity_even(parity_even), .two_stop(two_stop),
    .fifo_en(fifo_en), .rx_in(rx_in), .rd_en(rd_en), .rd_data(rd_data),
    .rx_empty(rx_empty), .rx_irq(rx_irq), .rx_timeout(rx_timeout)
  );

  always @(negedge clk) if (rx_timeout) to_cnt++;

  task automatic chk(input bit ok, input string tag, input [31:0] act, input [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    report();
  end

  function automatic [11:0] exp_word(input [7:0] d, input bit pb, input bit s0, input bit s1);
    int n = int'(word_len) + 5;
    logic [7:0] dm = d & 8'((1 << n) - 1);
    bit low_any = !s0 || (two_stop && !s1);
    bit low_all = !s0 && (!two_stop || !s1);
    bit b = low_all && dm == 0 && (!parity_en || !pb);
    int ones = $countones(dm) + int'(pb);
    bit p = parity_en && !b && (parity_even ? (ones % 2 == 1) : (ones % 2 == 0));
    exp_word = {b, 1'b0, p, low_any && !b, dm};
  endfunction

  function automatic bit good_par(input [7:0] d);
    int n = int'(word_len) + 5;
    bit x = ^(d & 8'((1 << n) - 1));
    good_par = parity_even ? x : !x;
  endfunction

  task automatic model_push(input [11:0] w);
    int cap = fifo_en ? 16 : 1;
    if (q.size() < cap) q.push_back(w);
    else q[q.size() - 1] = q[q.size() - 1] | 12'h400;
  endtask

  task automatic bit_time(input bit v);
    rx_in = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_raw(input [7:0] d, input bit pb, input bit s0, input bit s1);
    int n = int'(word_len) + 5;
    bit_time(1'b0);
    for (int i = 0; i < n; i++) bit_time(d[i]);
    if (parity_en) bit_time(pb);
    bit_time(s0);
    if (two_stop) bit_time(s1);
    bit_time(1'b1);
    model_push(exp_word(d, pb, s0, s1));
  endtask

  task automatic send_ok(input [7:0] d);
    send_raw(d, good_par(d), 1'b1, 1'b1);
  endtask

  task automatic read_chk(input string tag);
    @(negedge clk);
    chk(rx_empty == (q.size() == 0), "R8 empty", 32'(rx_empty), 32'(q.size() == 0));
    if (q.size() > 0) begin
      chk(rd_data == q[0], tag, 32'(rd_data), 32'(q[0]));
      void'(q.pop_front());
    end
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic irq_chk();
    bit e = fifo_en ? (q.size() >= 8) : (q.size() != 0);
    chk(rx_irq == e, "R9 irq", 32'(rx_irq), 32'(e));
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) read_chk(tag);
    @(negedge clk);
    chk(rx_empty == 1'b1, "R8 drained", 32'(rx_empty), 32'd1);
  endtask

  initial begin
    int base;
    void'($urandom(32'd13579));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_empty == 1'b1, "R8 reset empty", 32'(rx_empty), 32'd1);
    chk(rx_irq == 1'b0, "R9 reset irq", 32'(rx_irq), 32'd0);
    chk(rx_timeout == 1'b0, "R10 reset timeout", 32'(rx_timeout), 32'd0);
    bit_time(1'b1);

    // R1 R2: 8-bit and 5-bit frames
    send_ok(8'hA5); read_chk("R1 8-bit char");
    word_len = 2'b00; send_ok(8'hFF); read_chk("R2 5-bit masked");
    word_len = 2'b01; send_ok(8'h2A); read_chk("R2 6-bit");

    // R3 parity, even then odd, correct then corrupted
    word_len = 2'b10; parity_en = 1'b1;
    parity_even = 1'b1; send_raw(8'h35, good_par(8'h35), 1, 1); read_chk("R3 even ok");
    send_raw(8'h35, !good_par(8'h35), 1, 1); read_chk("R3 even bad");
    parity_even = 1'b0; send_raw(8'h11, !good_par(8'h11), 1, 1); read_chk("R3 odd bad");
    send_raw(8'h11, good_par(8'h11), 1, 1); read_chk("R3 odd ok");

    // R4 framing: second stop low, then single stop low
    parity_en = 1'b0; word_len = 2'b11; two_stop = 1'b1;
    send_raw(8'h5C, 1'b0, 1'b1, 1'b0); read_chk("R4 second stop low");
    two_stop = 1'b0;
    send_raw(8'h81, 1'b0, 1'b0, 1'b1); read_chk("R4 stop low");

    // R5 break with parity enabled, followed by a normal char
    parity_en = 1'b1; parity_even = 1'b1;
    send_raw(8'h00, 1'b0, 1'b0, 1'b0); read_chk("R5 break");
    send_ok(8'h7E); read_chk("R5 after break");
    parity_en = 1'b0;

    // R9 threshold, R6 depth/order, R7 overrun
    for (int i = 0; i < 17; i++) begin
      send_ok(8'(i * 7 + 3));
      irq_chk();
    end
    chk(q[15][10] == 1'b1, "R7 model tag", 32'(q[15]), 32'h400);
    drain("R6 R7 fifo order/overrun");

    // single-entry mode
    fifo_en = 1'b0;
    send_ok(8'h44); irq_chk();
    send_ok(8'h99); irq_chk();
    read_chk("R6 R7 single entry overrun");
    @(negedge clk);
    chk(rx_empty == 1'b1, "R6 single depth", 32'(rx_empty), 32'd1);
    fifo_en = 1'b1;

    // R12 read while empty
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
    chk(rx_empty == 1'b1, "R12 empty read", 32'(rx_empty), 32'd1);
    send_ok(8'h3C); read_chk("R12 next char intact");

    // R11 glitch shorter than half a bit
    rx_in = 1'b0; repeat (4 * (DIV + 1)) @(negedge clk);
    bit_time(1'b1); bit_time(1'b1);
    chk(rx_empty == 1'b1, "R11 glitch ignored", 32'(rx_empty), 32'd1);

    // R10 timeout
    base = to_cnt;
    send_ok(8'h12);
    repeat (20 * BIT) @(negedge clk);
    chk(to_cnt == base, "R10 early", 32'(to_cnt - base), 32'd0);
    repeat (20 * BIT) @(negedge clk);
    chk(to_cnt == base + 1, "R10 fired once", 32'(to_cnt - base), 32'd1);
    read_chk("R10 char");

    // random segments
    for (int s = 0; s < 4; s++) begin
      fifo_en = (s % 2 == 0);
      for (int f = 0; f < 36; f++) begin
        logic [7:0] d = 8'($urandom);
        int r = $urandom_range(0, 15);
        word_len = 2'($urandom); parity_en = 1'($urandom);
        parity_even = 1'($urandom); two_stop = 1'($urandom);
        if (r == 0) send_raw(8'h00, 1'b0, 1'b0, 1'b0);
        else if (r == 1) send_raw(d, !good_par(d), 1'b1, 1'b1);
        else if (r == 2) send_raw(d, good_par(d), 1'($urandom), 1'b0);
        else send_ok(d);
        irq_chk();
        for (int k = $urandom_range(0, 1); k > 0; k--) read_chk("R1 R6 random");
      end
      drain("R1 R6 random drain");
    end

    report();
  end

endmodule